// File: doc/BRIEF.md
# Multi-Channel Interprocessor Message Mailbox

This block lets several processors pass 32-bit messages to one another through a bank of independent one-way mailboxes. Each mailbox has one fixed writing processor and one fixed reading processor. The writer stores a word at the mailbox's message address, and the word joins a short first-in first-out queue. The reader pops the oldest word by reading the same address. A per-mailbox status word reports how many messages are queued and whether the queue is full.

Each mailbox has two sticky event bits. The new-message bit raises an interrupt towards the mailbox's reader. The overflow bit records a write that arrived while the queue was full, and it raises an interrupt towards the mailbox's writer. Every event bit has its own enable. Each processor gets one interrupt line, which is the OR of all enabled events addressed to it.

All access goes through one word-addressed register port that takes one access per cycle. Read data is registered and appears on the cycle after the read strobe.

Top module: `mbox_top`

## Requirements
- R1: After reset every queue is empty, every count, event bit and enable reads 0, `irq` is all zero and `reg_rdata` is 0.
- R2: A write to address 0x00+m (m below the mailbox count, 12 by default) with a queue that is not full adds the word to mailbox m's queue. The count field, bits [2:0] of the word at 0x10+m, then goes up by one.
- R3: A read of address 0x00+m returns mailbox m's oldest queued word on `reg_rdata` one cycle after the strobe, removes that word and lowers the count by one. Words come out in the order they were written.
- R4: A queue holds at most 4 words. At 4, bit 8 of the word at 0x10+m reads 1. A write to a full queue is dropped: the count and the queued words stay as they were, and mailbox m's overflow bit (bit 16+m of address 0x20) is set.
- R5: A read of an empty mailbox's message address returns 0 and leaves the count at 0.
- R6: The new-message bit of mailbox m (bit m of address 0x20) is set by an accepted write. Writing 1 to it clears it only when the queue is empty. While the queue holds a word, the bit reads 1.
- R7: Writing 1 to an overflow bit at address 0x20 clears it. Bits written with 0 keep their value.
- R8: The enable word at address 0x21 uses the same bit layout as the event word and reads back as written. Mailbox m is written by processor m mod 4 and read by processor (m+1) mod 4. `irq[u]` is 1 exactly when some enabled new-message bit has receiver u, or some enabled overflow bit has sender u.
- R9: Writes to an unmapped address, including a message or status address with m of 12 or more, change nothing. Reads of an unmapped address return 0.
- R10: Traffic on one mailbox leaves every other mailbox's count, contents and event bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe; takes priority over a read in the same cycle |
| reg_re | input | 1 | Read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_re` |
| irq | output | 4 | One interrupt line per processor |

## Verification
The queue path is tried with long directed bursts on a single mailbox: filling it to the brim, writing past full, and draining it past empty. These bursts separate correct ordering and drop-on-full from pointer wrap or count errors. Interleaved random writes, reads, event clears and enable changes over all twelve mailboxes separate true per-mailbox isolation and correct sender/receiver routing of the interrupt lines from cross-talk. Clearing the new-message bit is tried both with words still queued and with the queue drained, which separates the level-held behaviour from a plain sticky bit.

// File: rtl/mbox_pkg.sv
// Package: address map and sender/receiver routing shared by the mailbox block.
// Assumes at most 16 mailboxes, so each address group fits in 16 words.
package mbox_pkg;
    localparam int          ADDR_W    = 8;
    localparam logic [3:0]  GRP_MSG   = 4'h0;   // message push/pop window
    localparam logic [3:0]  GRP_CNT   = 4'h1;   // count / full window
    localparam logic [7:0]  ADDR_EVT  = 8'h20;  // event bits, write 1 to clear
    localparam logic [7:0]  ADDR_ENA  = 8'h21;  // event enables
    localparam int          FULL_BIT  = 8;      // full flag position in count word
    localparam int          OVF_OFS   = 16;     // overflow field offset in event word

    // Processor that writes mailbox m.
    function automatic int sender_of(input int m, input int n_users);
        return m % n_users;
    endfunction

    // Processor that reads mailbox m.
    function automatic int receiver_of(input int m, input int n_users);
        return (m + 1) % n_users;
    endfunction
endpackage

// File: rtl/mbox_fifo.sv
// Module: one mailbox queue. Accepts a push when not full, pops on request
// when not empty, and pulses ovf_evt when a push meets a full queue.
// Assumes push and pop never arrive in the same cycle (the port decoder
// guarantees this).
module mbox_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          ovf_evt
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign ovf_evt = push && full;
    assign head    = mem[rd_ptr];

    // Pointer advance with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (push_ok) begin
            wr_ptr <= bump(wr_ptr);
            count  <= count + 1'b1;
        end else if (pop && !empty) begin
            rd_ptr <= bump(rd_ptr);
            count  <= count - 1'b1;
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_drop_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (count == CW'(DEPTH)));
    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (count == '0));
endmodule

// File: rtl/mbox_irq.sv
// Module: event bits, enables and per-processor interrupt routing.
// Assumes the event and enable words share the layout: new-message bits at
// [NUM_MBOX-1:0], overflow bits at [OVF_OFS+NUM_MBOX-1:OVF_OFS].
module mbox_irq
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 12,
    parameter int NUM_USER = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MBOX-1:0] push_ok,
    input  logic [NUM_MBOX-1:0] nonempty,
    input  logic [NUM_MBOX-1:0] ovf_evt,
    input  logic                evt_clr_we,
    input  logic                ena_we,
    input  logic [31:0]         wdata,
    output logic [NUM_MBOX-1:0] new_sts,
    output logic [NUM_MBOX-1:0] ovf_sts,
    output logic [NUM_MBOX-1:0] new_en,
    output logic [NUM_MBOX-1:0] ovf_en,
    output logic [NUM_USER-1:0] irq
);
    logic [NUM_MBOX-1:0] new_clr, ovf_clr;

    assign new_clr = evt_clr_we ? wdata[NUM_MBOX-1:0] : '0;
    assign ovf_clr = evt_clr_we ? wdata[OVF_OFS +: NUM_MBOX] : '0;

    // Sticky event bits: set has priority, new-message held while queue non-empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_sts <= '0;
            ovf_sts <= '0;
        end else begin
            new_sts <= (new_sts & ~new_clr) | push_ok | nonempty;
            ovf_sts <= (ovf_sts & ~ovf_clr) | ovf_evt;
        end
    end

    // Enable register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_en <= '0;
            ovf_en <= '0;
        end else if (ena_we) begin
            new_en <= wdata[NUM_MBOX-1:0];
            ovf_en <= wdata[OVF_OFS +: NUM_MBOX];
        end
    end

    // Interrupt line per processor: OR of enabled events routed to it.
    for (genvar u = 0; u < NUM_USER; u++) begin : g_user
        logic [NUM_MBOX-1:0] rcv_mask, snd_mask;
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_map
            assign rcv_mask[m] = (receiver_of(m, NUM_USER) == u);
            assign snd_mask[m] = (sender_of(m, NUM_USER) == u);
        end
        assign irq[u] = |(new_sts & new_en & rcv_mask) | |(ovf_sts & ovf_en & snd_mask);
    end

    assert_new_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nonempty & ~new_sts) == '0);
    assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf_evt) |=> ((ovf_sts & $past(ovf_evt)) == $past(ovf_evt)));
    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr_we && (|ovf_clr) && !(|ovf_evt)) |=> ((ovf_sts & $past(ovf_clr)) == '0));
endmodule

// File: rtl/mbox_top.sv
// Module: mailbox bank top. Decodes the word-addressed register port, holds
// one queue per mailbox and registers read data.
// Assumes one access per cycle; a write in the same cycle as a read wins and
// the read is ignored. NUM_MBOX must be 16 or less.
module mbox_top
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 12,
    parameter int NUM_USER = 4,
    parameter int DEPTH    = 4,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic                reg_re,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic [NUM_USER-1:0] irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [3:0]          idx;
    logic                idx_ok, msg_hit, cnt_hit, rd_ok;
    logic [NUM_MBOX-1:0] push, pop, push_ok, nonempty, fullv, ovf_evt;
    logic [NUM_MBOX-1:0] new_sts, ovf_sts, new_en, ovf_en;
    logic [DW-1:0]       head [NUM_MBOX];
    logic [CW-1:0]       cnt  [NUM_MBOX];
    logic [DW-1:0]       rd_mux;

    assign idx     = reg_addr[3:0];
    assign idx_ok  = (32'(idx) < NUM_MBOX);
    assign msg_hit = (reg_addr[7:4] == GRP_MSG) && idx_ok;
    assign cnt_hit = (reg_addr[7:4] == GRP_CNT) && idx_ok;
    assign rd_ok   = reg_re && !reg_we;

    // One queue per mailbox with its own push/pop strobe.
    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mb
        logic empty_m;
        assign push[m]     = reg_we && msg_hit && (idx == 4'(m));
        assign pop[m]      = rd_ok  && msg_hit && (idx == 4'(m));
        assign nonempty[m] = !empty_m;
        mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push[m]),
            .pop     (pop[m]),
            .wdata   (reg_wdata),
            .head    (head[m]),
            .count   (cnt[m]),
            .full    (fullv[m]),
            .empty   (empty_m),
            .push_ok (push_ok[m]),
            .ovf_evt (ovf_evt[m])
        );
    end

    mbox_irq #(.NUM_MBOX(NUM_MBOX), .NUM_USER(NUM_USER)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_ok    (push_ok),
        .nonempty   (nonempty),
        .ovf_evt    (ovf_evt),
        .evt_clr_we (reg_we && (reg_addr == ADDR_EVT)),
        .ena_we     (reg_we && (reg_addr == ADDR_ENA)),
        .wdata      (reg_wdata),
        .new_sts    (new_sts),
        .ovf_sts    (ovf_sts),
        .new_en     (new_en),
        .ovf_en     (ovf_en),
        .irq        (irq)
    );

    // Read multiplexer: message head, count word, event word or enable word.
    always_comb begin
        rd_mux = '0;
        if (msg_hit) begin
            if (nonempty[idx]) rd_mux = head[idx];
        end else if (cnt_hit) begin
            rd_mux[CW-1:0]   = cnt[idx];
            rd_mux[FULL_BIT] = fullv[idx];
        end else if (reg_addr == ADDR_EVT) begin
            rd_mux[NUM_MBOX-1:0]        = new_sts;
            rd_mux[OVF_OFS +: NUM_MBOX] = ovf_sts;
        end else if (reg_addr == ADDR_ENA) begin
            rd_mux[NUM_MBOX-1:0]        = new_en;
            rd_mux[OVF_OFS +: NUM_MBOX] = ovf_en;
        end
    end

    // Registered read data, updated only on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_rdata <= '0;
        else if (rd_ok) reg_rdata <= rd_mux;
    end

    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && msg_hit && !nonempty[idx]) |=> (reg_rdata == '0));
    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !msg_hit && !cnt_hit && reg_addr != ADDR_EVT && reg_addr != ADDR_ENA)
        |=> (reg_rdata == '0));
    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((new_en == '0) && (ovf_en == '0)) |-> (irq == '0));
endmodule

// File: tb/sim_mbox_top.sv
// Bench: directed corner cases plus seeded random traffic against a
// behavioural model of queues, event bits and interrupt routing.
module sim_mbox_top;
    localparam int NM = 12;
    localparam int NU = 4;
    localparam int DP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NU-1:0] irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Model state.
    logic [31:0] mq [NM][DP];
    int          mcnt [NM];
    logic [NM-1:0] m_new, m_ovf, m_nen, m_oen;

    always #5 clk = ~clk;

    mbox_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NU-1:0] exp_irq();
        logic [NU-1:0] r = '0;
        for (int m = 0; m < NM; m++) begin
            if (m_new[m] && m_nen[m]) r[(m + 1) % NU] = 1'b1;
            if (m_ovf[m] && m_oen[m]) r[m % NU] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_cnt_word(input int m);
        logic [31:0] w = '0;
        w[2:0] = 3'(mcnt[m]);
        w[8]   = (mcnt[m] == DP);
        return w;
    endfunction

    function automatic logic [31:0] exp_evt_word();
        logic [31:0] w = '0;
        w[NM-1:0]  = m_new;
        w[16 +: NM] = m_ovf;
        return w;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        // Model update.
        if (a[7:4] == 4'h0 && a[3:0] < NM) begin
            if (mcnt[a[3:0]] < DP) begin
                mq[a[3:0]][mcnt[a[3:0]]] = d;
                mcnt[a[3:0]]++;
                m_new[a[3:0]] = 1'b1;
            end else m_ovf[a[3:0]] = 1'b1;
        end else if (a == 8'h20) begin
            for (int m = 0; m < NM; m++) begin
                if (d[m] && mcnt[m] == 0) m_new[m] = 1'b0;
                if (d[16 + m]) m_ovf[m] = 1'b0;
            end
        end else if (a == 8'h21) begin
            m_nen = d[NM-1:0];
            m_oen = d[16 +: NM];
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    // Pop expected word from the model (0 when empty).
    function automatic logic [31:0] model_pop(input int m);
        logic [31:0] v = '0;
        if (mcnt[m] > 0) begin
            v = mq[m][0];
            for (int i = 0; i < DP - 1; i++) mq[m][i] = mq[m][i + 1];
            mcnt[m]--;
        end
        return v;
    endfunction

    initial begin : watchdog
        #1_500_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, e;
        for (int m = 0; m < NM; m++) mcnt[m] = 0;
        m_new = '0; m_ovf = '0; m_nen = '0; m_oen = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        bus_read(8'h10, d); check("R1 count0", d, 32'h0);
        bus_read(8'h20, d); check("R1 events", d, 32'h0);
        bus_read(8'h21, d); check("R1 enables", d, 32'h0);

        // R2/R4: fill mailbox 3, then overflow
        for (int i = 0; i < DP; i++) begin
            bus_write(8'h03, 32'hA000_0000 + i);
            bus_read(8'h13, d); check("R2 count rises", d, exp_cnt_word(3));
        end
        check("R4 full flag", d[8], 1'b1);
        bus_write(8'h03, 32'hDEAD_BEEF);
        bus_read(8'h13, d); check("R4 dropped count", d, 32'h104);
        bus_read(8'h20, d); check("R4 overflow bit", d, exp_evt_word());
        bus_read(8'h15, d); check("R10 other mailbox untouched", d, 32'h0);

        // R8: overflow routes to sender 3, new-message to receiver 0
        bus_write(8'h21, 32'h1 << (16 + 3));
        check("R8 irq ovf to sender", 32'(irq), 32'(exp_irq()));
        bus_write(8'h21, 32'h1 << 3);
        check("R8 irq new to receiver", 32'(irq), 32'(exp_irq()));

        // R6: clear new-message while non-empty keeps it
        bus_write(8'h20, 32'h1 << 3);
        bus_read(8'h20, d); check("R6 held while queued", d[3], 1'b1);

        // R7: clear overflow
        bus_write(8'h20, 32'h1 << (16 + 3));
        bus_read(8'h20, d); check("R7 overflow cleared", d, exp_evt_word());

        // R3: drain in order; R5 read past empty
        for (int i = 0; i < DP; i++) begin
            bus_read(8'h03, d); e = model_pop(3);
            check("R3 order", d, e);
        end
        bus_read(8'h03, d); check("R5 empty read zero", d, 32'h0);
        bus_read(8'h13, d); check("R5 count stays zero", d, 32'h0);
        bus_write(8'h20, 32'h1 << 3);
        bus_read(8'h20, d); check("R6 cleared once empty", d[3], 1'b0);
        check("R8 irq drops", 32'(irq), 32'(exp_irq()));

        // R9: unmapped addresses
        bus_write(8'h0C, 32'h1234_5678);
        bus_write(8'h55, 32'hFFFF_FFFF);
        bus_read(8'h0C, d); check("R9 unmapped read", d, 32'h0);
        bus_read(8'h1C, d); check("R9 invalid count read", d, 32'h0);
        bus_read(8'h20, d); check("R9 no side effect", d, exp_evt_word());

        // Random traffic across all mailboxes
        for (int n = 0; n < 800; n++) begin
            int op, m;
            op = int'($urandom % 10);
            m  = int'($urandom % NM);
            case (op)
                0, 1, 2, 3: bus_write(8'(m), $urandom);
                4, 5, 6: begin
                    bus_read(8'(m), d); e = model_pop(m);
                    check("R3/R5 random pop", d, e);
                end
                7: begin
                    bus_read(8'h10 + 8'(m), d);
                    check("R2/R10 random count", d, exp_cnt_word(m));
                end
                8: begin
                    bus_write(8'h20, $urandom & 32'h0FFF_0FFF);
                    bus_read(8'h20, d);
                    check("R6/R7 random events", d, exp_evt_word());
                end
                default: begin
                    bus_write(8'h21, $urandom & 32'h0FFF_0FFF);
                    bus_read(8'h21, d);
                    check("R8 enable readback", d, {4'h0, m_oen, 4'h0, m_nen});
                end
            endcase
            check("R8 random irq", 32'(irq), 32'(exp_irq()));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule